// File: doc/BRIEF.md
# Stipple and Blit Engine

This block speeds up 2D drawing on an 8-bit-per-pixel linear framebuffer whose lines are 1024 pixels wide. The pixel store is a synchronous RAM inside the block, and its size is set by a parameter. A bus master starts work with single 32-bit writes. The pixel destination is taken from the bus byte address, and the data word tells the engine what to draw.

There are three kinds of write:
- A colour write loads the drawing colour.
- A stipple write expands a 32-bit mask into a run of 32 pixels. Only the pixels whose mask bit is set are painted.
- A blit write fills a run of 1 to 32 pixels with the colour, or copies a run from a source pixel index.

The engine touches at most one pixel per cycle. While it works it holds `busy` high and `cmd_ready` low. When a command finishes, it pulses a dirty report with the first destination pixel and the run length, so a display refresh can limit itself to that range. A second read port lets the scan-out logic read pixels independently.

Top module: `pix_accel`

## Requirements
- R1: After reset `busy` is 0, `cmd_ready` is 1, `dirty_valid` is 0 and the drawing colour is 0.
- R2: The destination pixel index is `cmd_addr[22:3]`, 20 bits wide. The RAM is addressed with this index taken modulo 2^ADDR_W, and each later pixel of a run wraps modulo 2^ADDR_W as well.
- R3: A stipple command (`cmd_sel`=1) maps data bit 31 to the destination pixel, bit 30 to the next pixel, and so on down to bit 0 for the 32nd pixel. A pixel whose bit is 1 takes the colour; a pixel whose bit is 0 keeps its value. The command always takes 32 cycles.
- R4: A blit command (`cmd_sel`=2) takes a source pixel index from data bits 23:0 and a run length of data bits 28:24 plus one, so runs are 1 to 32 pixels long. Data bits 31:29 are ignored.
- R5: A blit whose source field is 0xFFFFFF fills the run with the colour. It takes one cycle per pixel.
- R6: Any other blit copies pixels one by one, in increasing index order. It reads pixel k of the source before it writes pixel k of the destination, so an overlapping forward copy gives the same result as a sequential loop. It takes two cycles per pixel, and the source index wraps modulo 2^ADDR_W.
- R7: From the cycle after a stipple or blit command is accepted until that command completes, `busy` is 1 and `cmd_ready` is 0.
- R8: On the cycle after the last pixel of a command is written, `dirty_valid` is 1 for exactly one cycle. In that cycle `dirty_addr` holds the 20-bit destination index and `dirty_len` holds the pixel count: 32 for a stipple, the run length for a blit.
- R9: A read (`cmd_we`=0) of any window returns 0 on `cmd_rdata` and has no effect. A write with `cmd_sel`=3 has no effect.
- R10: A colour write (`cmd_sel`=0) loads data bits 7:0 as the drawing colour, which is used by all later stipple and fill commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine can accept a command |
| cmd_we | input | 1 | 1 = write, 0 = read |
| cmd_sel | input | 2 | 0 colour, 1 stipple, 2 blit, 3 unused |
| cmd_addr | input | 32 | Bus byte address |
| cmd_wdata | input | 32 | Write data |
| cmd_rdata | output | 32 | Read data, always zero |
| busy | output | 1 | Operation in progress |
| disp_addr | input | ADDR_W | Scan-out read index |
| disp_data | output | 8 | Pixel at disp_addr, one cycle later |
| dirty_valid | output | 1 | Completion pulse |
| dirty_addr | output | 20 | First destination pixel of the finished command |
| dirty_len | output | 6 | Pixel count of the finished command |

## Verification
The bench builds the engine with ADDR_W=10, so the RAM holds exactly one 1024-pixel line. With that size, random 20-bit destinations and 24-bit sources wrap inside the RAM constantly, which exercises the modulo addressing of R2 and R6. The small RAM also lets the bench compare the whole RAM against its model after each directed case and after every few random commands.

// File: rtl/pix_accel.sv
module pix_accel #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_we,
  input  logic [1:0]        cmd_sel,
  input  logic [31:0]       cmd_addr,
  input  logic [31:0]       cmd_wdata,
  output logic [31:0]       cmd_rdata,
  output logic              busy,
  input  logic [ADDR_W-1:0] disp_addr,
  output logic [7:0]        disp_data,
  output logic              dirty_valid,
  output logic [19:0]       dirty_addr,
  output logic [5:0]        dirty_len
);
  localparam int DEPTH = 1 << ADDR_W;

  typedef enum logic [2:0] {S_IDLE, S_STIP, S_FILL, S_CRD, S_CWR} st_t;

  st_t               st;
  logic [7:0]        mem [DEPTH];
  logic [7:0]        color_q, rd_q;
  logic [31:0]       mask_q;
  logic [ADDR_W-1:0] dst_q, src_q;
  logic [4:0]        cnt_q;
  logic              op_stip;
  logic              accept, mem_we, last;
  logic [7:0]        mem_wd;
  logic [19:0]       dst_idx;

  assign busy      = (st != S_IDLE);
  assign cmd_ready = !busy;
  assign cmd_rdata = '0;
  assign accept    = cmd_valid && cmd_ready && cmd_we;
  assign dst_idx   = cmd_addr[22:3];
  assign mem_we    = (st == S_STIP && mask_q[31]) || st == S_FILL || st == S_CWR;
  assign mem_wd    = (st == S_CWR) ? rd_q : color_q;
  assign last      = (cnt_q == 5'd0);

  always_ff @(posedge clk) begin
    if (mem_we) mem[dst_q] <= mem_wd;
    rd_q      <= mem[src_q];
    disp_data <= mem[disp_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      color_q     <= '0;
      mask_q      <= '0;
      dst_q       <= '0;
      src_q       <= '0;
      cnt_q       <= '0;
      op_stip     <= 1'b0;
      dirty_valid <= 1'b0;
      dirty_addr  <= '0;
      dirty_len   <= '0;
    end else begin
      dirty_valid <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          case (cmd_sel)
            2'd0: color_q <= cmd_wdata[7:0];
            2'd1: begin
              mask_q     <= cmd_wdata;
              dst_q      <= dst_idx[ADDR_W-1:0];
              cnt_q      <= 5'd31;
              dirty_addr <= dst_idx;
              dirty_len  <= 6'd32;
              op_stip    <= 1'b1;
              st         <= S_STIP;
            end
            2'd2: begin
              dst_q      <= dst_idx[ADDR_W-1:0];
              src_q      <= cmd_wdata[ADDR_W-1:0];
              cnt_q      <= cmd_wdata[28:24];
              dirty_addr <= dst_idx;
              dirty_len  <= {1'b0, cmd_wdata[28:24]} + 6'd1;
              op_stip    <= 1'b0;
              st         <= (cmd_wdata[23:0] == 24'hFF_FFFF) ? S_FILL : S_CRD;
            end
            default: ;
          endcase
        end
        S_STIP, S_FILL: begin
          mask_q <= mask_q << 1;
          dst_q  <= dst_q + 1'b1;
          cnt_q  <= cnt_q - 1'b1;
          if (last) begin
            st          <= S_IDLE;
            dirty_valid <= 1'b1;
          end
        end
        S_CRD: st <= S_CWR;
        S_CWR: begin
          dst_q <= dst_q + 1'b1;
          src_q <= src_q + 1'b1;
          cnt_q <= cnt_q - 1'b1;
          if (last) begin
            st          <= S_IDLE;
            dirty_valid <= 1'b1;
          end else begin
            st <= S_CRD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r8_dirty_single: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_valid |=> !dirty_valid);
  a_r8_dirty_len: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_valid |-> (dirty_len >= 6'd1 && dirty_len <= 6'd32));
  a_r3_stip_count: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty_valid && op_stip) |-> dirty_len == 6'd32);
  a_r7_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_we && (cmd_sel == 2'd1 || cmd_sel == 2'd2)) |=> busy);
  a_r10_color_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(color_q));
  a_r9_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_we) |-> cmd_rdata == 32'd0);
endmodule

// File: tb/pix_accel_tb.sv
module pix_accel_tb;
  localparam int AW = 10;
  localparam int N  = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_we = 0;
  logic [1:0] cmd_sel = 0;
  logic [31:0] cmd_addr = 0, cmd_wdata = 0;
  logic cmd_ready, busy, dirty_valid;
  logic [31:0] cmd_rdata;
  logic [AW-1:0] disp_addr = 0;
  logic [7:0] disp_data;
  logic [19:0] dirty_addr;
  logic [5:0] dirty_len;

  int n_chk = 0, n_bad = 0;
  logic [7:0] ref_mem [N];
  logic [7:0] ref_col = 0;

  always #10 clk = ~clk;

  pix_accel #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_we(cmd_we), .cmd_sel(cmd_sel), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .busy(busy), .disp_addr(disp_addr), .disp_data(disp_data),
    .dirty_valid(dirty_valid), .dirty_addr(dirty_addr), .dirty_len(dirty_len));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [1:0] sel, input logic [19:0] pix, input logic [31:0] d);
    int dst = pix % N;
    if (sel == 2'd0) ref_col = d[7:0];
    else if (sel == 2'd1) begin
      for (int i = 0; i < 32; i++) if (d[31-i]) ref_mem[(dst+i)%N] = ref_col;
    end else if (sel == 2'd2) begin
      int len = d[28:24] + 1;
      int src = d[23:0] % N;
      for (int i = 0; i < len; i++)
        ref_mem[(dst+i)%N] = (d[23:0] == 24'hFFFFFF) ? ref_col : ref_mem[(src+i)%N];
    end
  endfunction

  task automatic issue(input bit we, input logic [1:0] sel, input logic [19:0] pix,
                       input logic [2:0] lo, input logic [31:0] d, input string req);
    int exp_cyc, cyc;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_we = we; cmd_sel = sel;
    cmd_addr = {9'd0, pix, lo}; cmd_wdata = d;
    if (!we) chk(cmd_rdata == 0, "R9 read data", cmd_rdata, 0);
    @(negedge clk);
    cmd_valid = 0;
    if (we) model(sel, pix, d);
    if (we && (sel == 2'd1 || sel == 2'd2)) begin
      chk(busy && !cmd_ready, "R7 busy after accept", {busy, cmd_ready}, 2);
      exp_cyc = (sel == 2'd1) ? 33 : (d[23:0] == 24'hFFFFFF) ? d[28:24] + 2 : 2 * (d[28:24] + 1) + 1;
      cyc = 1;
      while (!dirty_valid && cyc < 200) begin
        @(negedge clk); cyc++;
        if (!dirty_valid && cmd_ready) break;
      end
      chk(cyc == exp_cyc, {req, " cycle count"}, cyc, exp_cyc);
      chk(dirty_valid && dirty_addr == pix, "R8 dirty addr", dirty_addr, pix);
      chk(dirty_len == ((sel == 2'd1) ? 32 : d[28:24] + 1), "R8 dirty len", dirty_len,
          (sel == 2'd1) ? 32 : d[28:24] + 1);
      @(negedge clk);
      chk(!dirty_valid, "R8 single pulse", dirty_valid, 0);
    end
  endtask

  task automatic cmp_ram(input string req);
    int bad = -1, act = 0;
    for (int a = 0; a < N; a++) begin
      disp_addr = a[AW-1:0];
      @(negedge clk);
      if (bad < 0 && disp_data !== ref_mem[a]) begin bad = a; act = disp_data; end
    end
    chk(bad < 0, req, act, (bad < 0) ? 0 : ref_mem[bad]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(42));
    repeat (3) @(negedge clk);
    chk(!busy && cmd_ready && !dirty_valid, "R1 reset state", {busy, cmd_ready, dirty_valid}, 2);
    rst_n = 1;
    // R1: colour resets to 0, so fills clear the RAM
    for (int k = 0; k < N / 32; k++) issue(1, 2'd2, 20'(k * 32), 3'd0, 32'h1FFF_FFFF, "R5 fill");
    cmp_ram("R1 R5 clear with reset colour");
    issue(1, 2'd0, 0, 0, 32'h1234_56AB, "R10");
    issue(1, 2'd1, 20'd5, 3'd7, 32'h8000_0001, "R3 stipple");
    cmp_ram("R3 R10 stipple ends");
    issue(1, 2'd1, 20'h0_03F0, 3'd0, 32'hF0F0_A5C3, "R3 stipple wrap");
    cmp_ram("R2 R3 stipple wraps");
    issue(1, 2'd0, 0, 0, 32'h0000_0077, "R10");
    issue(1, 2'd2, 20'hA_B123, 3'd2, 32'hE4FF_FFFF, "R5 fill");
    cmp_ram("R2 R4 R5 fill high index");
    issue(1, 2'd2, 20'd101, 3'd0, 32'h1F00_0064, "R6 copy");
    cmp_ram("R6 overlap forward copy");
    issue(1, 2'd2, 20'd200, 3'd0, 32'h0000_03FF, "R6 copy");
    issue(1, 2'd2, 20'd300, 3'd0, 32'h0A12_33F8, "R6 copy");
    cmp_ram("R4 R6 single and wrap copy");
    issue(0, 2'd1, 20'd40, 0, 32'hFFFF_FFFF, "R9");
    issue(1, 2'd3, 20'd40, 0, 32'hFFFF_FFFF, "R9");
    @(negedge clk);
    chk(cmd_ready && !dirty_valid, "R9 no effect handshake", {cmd_ready, dirty_valid}, 2);
    cmp_ram("R9 read and unused select leave RAM");
    for (int k = 0; k < 60; k++) begin
      logic [1:0] s = 2'($urandom % 3);
      logic [31:0] d = $urandom;
      if (s == 2 && ($urandom % 2) == 0) d[23:0] = 24'hFFFFFF;
      else if (s == 2 && d[23:0] == 24'hFFFFFF) d[0] = 1'b0;
      issue(1, s, 20'($urandom), 3'($urandom), d, "R2 random");
      if (k % 6 == 5) cmp_ram("R3 R5 R6 random sequence");
    end
    cmp_ram("R2 final contents");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule